// File: doc/BRIEF.md
# Dual-Port Memory Cycle Decoder

This block sits in the controller model of a dual-ported video memory. The memory has a random-access side and a serial-register side. Several of its control pins mean one thing at the instant the row strobe falls and something else for the rest of the access. The decoder runs on the system clock. It samples the active-low row and column strobes and finds their falling edges. At the row-strobe edge it freezes the cycle kind, the direction of a transfer, the extended-operation flag, the row address and the per-bit write mask. At a column-strobe edge inside the access it captures the column address.

When the shared transfer/output-enable pin is low at the row edge, the access is a transfer between the memory row and the serial register. Either byte write enable low then moves serial data into the array, and both high moves array data out to the serial register. When that pin is high at the row edge, the access is an ordinary random-access cycle. Either byte write enable low then makes it a masked write, and the data bus value becomes the mask. After the edge, the same pin acts as an active-low output enable. The byte write enables then choose between read and write.

The frozen values hold until the next row-strobe falling edge. A one-clock pulse marks each newly decoded cycle. A read-data-valid output is asserted while a non-transfer access is open, the output enable is low and both write enables are high.

Top module: `dpm_cycle_decoder`

## Requirements
- R1: After reset and before any row-strobe falling edge, the outputs are: cycle kind 0, direction 0, mask enable 0, mask all ones, row and column address 0, extended flag 0, new-cycle pulse 0, read-valid 0.
- R2: A row-strobe falling edge is a clock edge where the row strobe is sampled low and was sampled high at the previous edge. If the transfer/enable pin is low at that edge, the cycle kind takes bit 1 set (kind 2 or 3) from the following clock.
- R3: In a transfer cycle, the direction output is 1 (serial register to array, kind 3) if either byte write enable is low at the edge, and 0 (array to serial register, kind 2) if both are high.
- R4: In a non-transfer cycle, if either byte write enable is low at the edge, the cycle kind becomes 1 and mask enable becomes 1. If both are high, the kind becomes 0 and mask enable becomes 0. Mask enable is never 1 in a transfer cycle.
- R5: In a masked write cycle, the write mask equals the data bus at the row edge, where a 1 bit is written and a 0 bit keeps its stored data. In every other cycle the mask is all ones.
- R6: The row address output equals the 9-bit address bus sampled at the row-strobe falling edge.
- R7: The column address equals address bits 7..0 at a column-strobe falling edge (same detection rule as R2) that occurs while the row strobe is low. In a transfer cycle this value is the serial start address. Column-strobe edges while the row strobe is high are ignored.
- R8: The extended-operation output equals the special-function flag sampled at the row-strobe falling edge.
- R9: Cycle kind, direction, mask enable, mask, row address and extended flag change only on the clock after a row-strobe falling edge. Pin changes at any other time have no effect on them.
- R10: The new-cycle pulse is high for exactly the one clock following each row-strobe falling edge.
- R11: Read-valid is 1 exactly when an access is open (from the clock after the row edge until the row strobe is sampled high), the kind is 0 or 1, the transfer/enable pin is low and both byte write enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Transfer select at the row edge, output enable afterwards |
| we_hi_n | input | 1 | Upper byte write enable, active low |
| we_lo_n | input | 1 | Lower byte write enable, active low |
| sfn_flag | input | 1 | Special-function flag |
| dq | input | 16 | Data bus; mask source at the row edge |
| addr | input | 9 | Multiplexed address bus |
| cyc_type | output | 2 | 0 full write/read, 1 masked write, 2 array-to-serial transfer, 3 serial-to-array transfer |
| xfer_dir | output | 1 | Transfer direction, 1 = serial register to array |
| mask_en | output | 1 | Masked write mode |
| wmask | output | 16 | Per-bit write mask, 1 = write |
| row_addr | output | 9 | Latched row address |
| col_addr | output | 8 | Latched column / serial start address |
| ext_op | output | 1 | Extended operation requested |
| cyc_new | output | 1 | One-clock pulse after a new cycle is decoded |
| rd_valid | output | 1 | Read data valid |

## Verification
The bound checker checks several rules on every clock. A row edge produces the pulse and nothing else does. The row address matches the bus sampled one clock earlier. The frozen fields stay put between edges. A transfer cycle never shows mask enable. Read-valid never appears with the output enable high or a write enable low. Some behaviours only show up under the bench's stimulus, which drives all four cycle kinds, extreme masks and addresses, column edges outside the access, and pins changing after the edge. These are the exact decode of direction and kind, mask capture against the bus value, column capture gated by the row strobe, and the exact rise and fall of read-valid.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic [1:0] {
    CYC_RW_FULL     = 2'b00,
    CYC_RW_MASKED   = 2'b01,
    CYC_XFER_TO_SER = 2'b10,
    CYC_XFER_TO_RAM = 2'b11
  } cyc_e;

  // Kind of access from the pins held at the row-strobe falling edge.
  function automatic cyc_e decode_cycle(input logic xfer_n,
                                        input logic weh_n,
                                        input logic wel_n);
    logic any_we_low;
    any_we_low = ~(weh_n & wel_n);
    if (!xfer_n) decode_cycle = any_we_low ? CYC_XFER_TO_RAM : CYC_XFER_TO_SER;
    else         decode_cycle = any_we_low ? CYC_RW_MASKED   : CYC_RW_FULL;
  endfunction

  function automatic logic is_transfer(input cyc_e k);
    is_transfer = k[1];
  endfunction

  // A read may present data only inside an open non-transfer access.
  function automatic logic read_permitted(input logic act, input cyc_e k,
                                          input logic oe_n, input logic weh_n,
                                          input logic wel_n);
    read_permitted = act & ~is_transfer(k) & ~oe_n & weh_n & wel_n;
  endfunction

endpackage

// File: rtl/dpm_fall_det.sv
module dpm_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/dpm_row_latch.sv
module dpm_row_latch
  import dpm_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_fall,
  input  logic             ras_n,
  input  logic             xfer_n,
  input  logic             weh_n,
  input  logic             wel_n,
  input  logic             sfn,
  input  logic [DQ_W-1:0]  dq,
  input  logic [ROW_W-1:0] row_in,
  output cyc_e             kind_q,
  output logic             mask_en_q,
  output logic [DQ_W-1:0]  mask_q,
  output logic [ROW_W-1:0] row_q,
  output logic             ext_q,
  output logic             new_q,
  output logic             act_q
);
  cyc_e kind_d;
  logic masked_d;

  always_comb begin
    kind_d   = decode_cycle(xfer_n, weh_n, wel_n);
    masked_d = (kind_d == CYC_RW_MASKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= CYC_RW_FULL;
      mask_en_q <= 1'b0;
      mask_q    <= '1;
      row_q     <= '0;
      ext_q     <= 1'b0;
    end else if (row_fall) begin
      kind_q    <= kind_d;
      mask_en_q <= masked_d;
      mask_q    <= masked_d ? dq : '1;
      row_q     <= row_in;
      ext_q     <= sfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      new_q <= row_fall;
      if (row_fall)   act_q <= 1'b1;
      else if (ras_n) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dpm_col_latch.sv
module dpm_col_latch #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_fall,
  input  logic             ras_n,
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_q
);
  logic take;
  assign take = col_fall & ~ras_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    col_q <= '0;
    else if (take) col_q <= col_in;
  end
endmodule

// File: rtl/dpm_cycle_decoder.sv
module dpm_cycle_decoder
  import dpm_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int ROW_W = 9,
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              xfer_oe_n,
  input  logic              we_hi_n,
  input  logic              we_lo_n,
  input  logic              sfn_flag,
  input  logic [DQ_W-1:0]   dq,
  input  logic [ROW_W-1:0]  addr,
  output logic [1:0]        cyc_type,
  output logic              xfer_dir,
  output logic              mask_en,
  output logic [DQ_W-1:0]   wmask,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              ext_op,
  output logic              cyc_new,
  output logic              rd_valid
);
  localparam int NSTB   = 2;
  localparam int ADDR_W = ROW_W;

  logic [NSTB-1:0] strobes_n;
  logic [NSTB-1:0] falls;
  logic            ras_fall;
  logic            cas_fall;
  logic            cyc_act;
  cyc_e            kind;

  assign strobes_n = {cas_n, ras_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_edge
    dpm_fall_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe_n(strobes_n[g]),
      .fall    (falls[g])
    );
  end

  assign ras_fall = falls[0];
  assign cas_fall = falls[1];

  dpm_row_latch #(.DQ_W(DQ_W), .ROW_W(ROW_W)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_fall (ras_fall),
    .ras_n    (ras_n),
    .xfer_n   (xfer_oe_n),
    .weh_n    (we_hi_n),
    .wel_n    (we_lo_n),
    .sfn      (sfn_flag),
    .dq       (dq),
    .row_in   (addr[ADDR_W-1:0]),
    .kind_q   (kind),
    .mask_en_q(mask_en),
    .mask_q   (wmask),
    .row_q    (row_addr),
    .ext_q    (ext_op),
    .new_q    (cyc_new),
    .act_q    (cyc_act)
  );

  dpm_col_latch #(.COL_W(COL_W)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_fall(cas_fall),
    .ras_n   (ras_n),
    .col_in  (addr[COL_W-1:0]),
    .col_q   (col_addr)
  );

  assign cyc_type = kind;
  assign xfer_dir = (kind == CYC_XFER_TO_RAM);
  assign rd_valid = read_permitted(cyc_act, kind, xfer_oe_n, we_hi_n, we_lo_n);
endmodule

// File: rtl/dpm_cycle_decoder_chk.sv
module dpm_cycle_decoder_chk #(
  parameter int DQ_W  = 16,
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_fall,
  input logic             xfer_oe_n,
  input logic             we_hi_n,
  input logic             we_lo_n,
  input logic [ROW_W-1:0] addr,
  input logic [1:0]       cyc_type,
  input logic             mask_en,
  input logic [DQ_W-1:0]  wmask,
  input logic [ROW_W-1:0] row_addr,
  input logic             ext_op,
  input logic             cyc_new,
  input logic             rd_valid
);
  AST_XFER_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && !xfer_oe_n |=> cyc_type[1]); // R2
  AST_NO_MASK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type[1] |-> !mask_en); // R4
  AST_MASK_FULL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |-> wmask == '1); // R5
  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall |=> row_addr == $past(addr)); // R6
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_fall |=> $stable(cyc_type) && $stable(wmask) && $stable(row_addr) && $stable(ext_op)); // R9
  AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall |=> cyc_new); // R10
  AST_PULSE_ONLY_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_fall |=> !cyc_new); // R10
  AST_READ_NEEDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !xfer_oe_n && we_hi_n && we_lo_n && !cyc_type[1]); // R11
endmodule

bind dpm_cycle_decoder dpm_cycle_decoder_chk #(.DQ_W(DQ_W), .ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_fall (ras_fall),
  .xfer_oe_n(xfer_oe_n),
  .we_hi_n  (we_hi_n),
  .we_lo_n  (we_lo_n),
  .addr     (addr),
  .cyc_type (cyc_type),
  .mask_en  (mask_en),
  .wmask    (wmask),
  .row_addr (row_addr),
  .ext_op   (ext_op),
  .cyc_new  (cyc_new),
  .rd_valid (rd_valid)
);

// File: tb/test_dpm_cycle_decoder.sv
module test_dpm_cycle_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, xfer_oe_n = 1'b1;
  logic we_hi_n = 1'b1, we_lo_n = 1'b1, sfn_flag = 1'b0;
  logic [15:0] dq = '0;
  logic [8:0]  addr = '0;
  logic [1:0]  cyc_type;
  logic        xfer_dir, mask_en, ext_op, cyc_new, rd_valid;
  logic [15:0] wmask;
  logic [8:0]  row_addr;
  logic [7:0]  col_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpm_cycle_decoder i_dpm_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .xfer_oe_n(xfer_oe_n), .we_hi_n(we_hi_n), .we_lo_n(we_lo_n),
    .sfn_flag(sfn_flag), .dq(dq), .addr(addr),
    .cyc_type(cyc_type), .xfer_dir(xfer_dir), .mask_en(mask_en),
    .wmask(wmask), .row_addr(row_addr), .col_addr(col_addr),
    .ext_op(ext_op), .cyc_new(cyc_new), .rd_valid(rd_valid)
  );

  // Behavioural reference: pin history as integers, one update per clock.
  int m_last_ras = 1, m_last_cas = 1;
  int m_kind = 0, m_dir = 0, m_men = 0, m_ext = 0, m_pulse = 0, m_open = 0;
  int m_mask = 'hFFFF, m_row = 0, m_col = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last_ras = 1; m_last_cas = 1; m_kind = 0; m_dir = 0; m_men = 0;
      m_ext = 0; m_pulse = 0; m_open = 0; m_mask = 'hFFFF; m_row = 0; m_col = 0;
    end else begin
      m_pulse = 0;
      if (m_last_ras == 1 && ras_n == 0) begin
        m_pulse = 1;
        m_open  = 1;
        m_row   = addr;
        m_ext   = sfn_flag;
        if (xfer_oe_n == 0) begin
          m_men = 0; m_mask = 'hFFFF;
          if (we_hi_n == 0 || we_lo_n == 0) begin m_kind = 3; m_dir = 1; end
          else begin m_kind = 2; m_dir = 0; end
        end else begin
          m_dir = 0;
          if (we_hi_n == 0 || we_lo_n == 0) begin m_kind = 1; m_men = 1; m_mask = dq; end
          else begin m_kind = 0; m_men = 0; m_mask = 'hFFFF; end
        end
      end else if (ras_n == 1) begin
        m_open = 0;
      end
      if (m_last_cas == 1 && cas_n == 0 && ras_n == 0) m_col = addr % 256;
      m_last_ras = ras_n;
      m_last_cas = cas_n;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every clock, 2 ns after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int exp_rv;
      exp_rv = (m_open == 1 && m_kind < 2 && xfer_oe_n == 0 && we_hi_n == 1 && we_lo_n == 1) ? 1 : 0;
      cmp("R2", "cyc_type", cyc_type, m_kind);
      cmp("R3", "xfer_dir", xfer_dir, m_dir);
      cmp("R4", "mask_en", mask_en, m_men);
      cmp("R5", "wmask", wmask, m_mask);
      cmp("R6", "row_addr", row_addr, m_row);
      cmp("R7", "col_addr", col_addr, m_col);
      cmp("R8", "ext_op", ext_op, m_ext);
      cmp("R10", "cyc_new", cyc_new, m_pulse);
      cmp("R11", "rd_valid", rd_valid, exp_rv);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  // One access: idle, row edge with the given pins, then pins change (R9).
  task automatic access(input logic oe, input logic weh, input logic wel,
                        input logic flag, input logic [15:0] d,
                        input logic [8:0] ra, input logic [7:0] ca,
                        input bit rd);
    step(); ras_n = 1'b1; cas_n = 1'b1;
    // Column edge while the row strobe is high must be ignored (R7).
    addr = 9'($urandom); cas_n = 1'b0; step(); cas_n = 1'b1; step();
    xfer_oe_n = oe; we_hi_n = weh; we_lo_n = wel; sfn_flag = flag;
    dq = d; addr = ra; ras_n = 1'b0; step();
    dq = 16'($urandom); sfn_flag = ~flag; addr = {1'b0, ca};
    xfer_oe_n = rd ? 1'b0 : 1'b1; we_hi_n = rd ? 1'b1 : 1'b0; we_lo_n = rd;
    step();
    cas_n = 1'b0; step();
    addr = 9'($urandom); step();
    xfer_oe_n = 1'b1; step();
    xfer_oe_n = 1'b0; we_lo_n = 1'b0; step();
    we_lo_n = rd; step();
    cas_n = 1'b1; step();
    ras_n = 1'b1; step();
  endtask

  initial begin
    repeat (3) step();
    // R1: reset values.
    cmp("R1", "cyc_type", cyc_type, 0);
    cmp("R1", "mask_en", mask_en, 0);
    cmp("R1", "wmask", wmask, 'hFFFF);
    cmp("R1", "row_addr", row_addr, 0);
    cmp("R1", "col_addr", col_addr, 0);
    cmp("R1", "cyc_new", cyc_new, 0);
    cmp("R1", "rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    step(); step();
    // R4 full write/read, R11 read path
    access(1'b1, 1'b1, 1'b1, 1'b0, 16'h1234, 9'h000, 8'h00, 1'b1);
    // R4 and R5 masked write, pattern with both bytes
    access(1'b1, 1'b0, 1'b1, 1'b1, 16'hA5A5, 9'h1FF, 8'hFF, 1'b0);
    access(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 9'h155, 8'h80, 1'b0);
    access(1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 9'h0AA, 8'h7F, 1'b1);
    // R2 and R3 transfers both ways, R8 flag, R7 serial start address
    access(1'b0, 1'b1, 1'b1, 1'b1, 16'h5A5A, 9'h100, 8'h7F, 1'b1);
    access(1'b0, 1'b0, 1'b1, 1'b0, 16'h00FF, 9'h0FF, 8'hFF, 1'b0);
    access(1'b0, 1'b1, 1'b0, 1'b1, 16'hFF00, 9'h001, 8'h01, 1'b1);
    for (int i = 0; i < 300; i++)
      access(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), 9'($urandom), 8'($urandom), 1'($urandom));
    step(); step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule